// File: doc/BRIEF.md
# Mode-Configurable Byte Permute Unit

The unit forms a 32-bit result by choosing, for each of its four output bytes, one of eight source bytes. Bytes 0 to 3 come from operand `opa` (byte 0 is the least significant). Bytes 4 to 7 come from operand `opb`. A 16-bit selector and a 3-bit mode control the choice. In generic mode every selector nibble names a source byte directly and can ask for that byte's top bit to be replicated. Six shortcut modes take only the two low selector bits and turn them into four byte indices. These modes give funnel extracts in both directions, byte and halfword replication, and clamps toward either edge.

An operation is accepted when `in_valid` is high. Its result appears one clock later on `result`, with `out_valid` high. When no operation is presented, the registered result keeps its last value.

Top module: `perm_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `result` are both cleared to zero on that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `result` is loaded only when `in_valid` is high and otherwise holds its value.
- R3: Mode 0 (generic): selector bits [4i+2:4i] give the source index for output byte i. Index 0-3 is byte 0-3 of `opa`; index 4-7 is byte 0-3 of `opb`.
- R4: Mode 0: if selector bit 4i+3 is set, output byte i becomes 0xFF when the chosen byte's bit 7 is 1, and 0x00 when it is 0.
- R5: Mode 1 (forward extract): with V = sel[1:0], output bytes 0..3 take source indices V, V+1, V+2, V+3.
- R6: Mode 2 (backward extract): output bytes 0..3 take indices V, V-1, V-2, V-3, each taken modulo 8.
- R7: Mode 3 (byte replicate): all four output bytes take index V.
- R8: Mode 6 (halfword replicate): with W = 2·sel[0], output bytes 0..3 take indices W, W+1, W, W+1.
- R9: Mode 4 (clamp left): output byte i takes index max(V, i), so byte 3 is always source byte 3.
- R10: Mode 5 (clamp right): output byte i takes index min(V, i), so byte 0 is always source byte 0.
- R11: In modes 1 to 6, selector bits [15:2] have no effect and no sign replication is applied.
- R12: Mode 7 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| opa | input | 32 | Source bytes 0 to 3 |
| opb | input | 32 | Source bytes 4 to 7 |
| sel | input | 16 | Byte selector |
| mode | input | 3 | Selection mode |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 32 | Permuted word |

## Verification
The assertions assume that `mode`, `sel`, `opa` and `opb` are known whenever `in_valid` is high. They also assume that reset is held for at least one edge before the first operation. The stimulus drives every input to a defined value on every cycle, including idle ones. Reset is held low for several edges before any operation is offered. The idle cycles placed between operations exercise the hold behaviour without ever leaving an input undefined.

// File: rtl/perm_pkg.sv
// Package: shared constants and the mode encoding of the byte permute unit.
// Assumes four output lanes, with one 4-bit selector nibble per lane.
package perm_pkg;
    localparam int LANES   = 4;
    localparam int BYTE_W  = 8;
    localparam int SRC_N   = 2 * LANES;
    localparam int IDX_W   = $clog2(SRC_N);
    localparam int NIB_W   = IDX_W + 1;
    localparam int WORD_W  = LANES * BYTE_W;
    localparam int SEL_W   = LANES * NIB_W;

    typedef enum logic [2:0] {
        PM_GENERIC = 3'd0,
        PM_FWD     = 3'd1,
        PM_BWD     = 3'd2,
        PM_REP8    = 3'd3,
        PM_CLAMP_L = 3'd4,
        PM_CLAMP_R = 3'd5,
        PM_REP16   = 3'd6,
        PM_ALT     = 3'd7
    } perm_mode_e;
endpackage

// File: rtl/perm_idx_gen.sv
// Module: derives, for every output lane, a source byte index and a sign flag
// from the selector and mode. Purely combinational. Assumes IDX_W >= 3.
module perm_idx_gen
    import perm_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int IW      = IDX_W,
    localparam int NW     = IW + 1,
    localparam int SW     = N_LANES * NW
) (
    input  logic [2:0]          mode,
    input  logic [SW-1:0]       sel,
    output logic [IW-1:0]       idx [N_LANES],
    output logic [N_LANES-1:0]  sx
);
    logic [IW-1:0] shift_v;

    // Zero-extend the two low selector bits used by the shortcut modes.
    always_comb shift_v = IW'(sel[1:0]);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        localparam logic [IW-1:0] LANE_IDX = IW'(i);

        // Lane index and sign flag for the current mode.
        always_comb begin
            sx[i] = 1'b0;
            case (perm_mode_e'(mode))
                PM_FWD:     idx[i] = shift_v + LANE_IDX;
                PM_BWD:     idx[i] = shift_v - LANE_IDX;
                PM_REP8:    idx[i] = shift_v;
                PM_CLAMP_L: idx[i] = (shift_v > LANE_IDX) ? shift_v : LANE_IDX;
                PM_CLAMP_R: idx[i] = (shift_v < LANE_IDX) ? shift_v : LANE_IDX;
                PM_REP16:   idx[i] = IW'({sel[0], LANE_IDX[0]});
                default: begin
                    idx[i] = sel[i*NW +: IW];
                    sx[i]  = sel[i*NW + IW];
                end
            endcase
        end
    end
endmodule

// File: rtl/perm_byte_sel.sv
// Module: picks one byte from a pool of source bytes and optionally replaces
// it with copies of its top bit. Combinational; assumes idx < N_SRC.
module perm_byte_sel #(
    parameter int BW    = 8,
    parameter int N_SRC = 8,
    parameter int IW    = $clog2(N_SRC)
) (
    input  logic [N_SRC*BW-1:0] pool,
    input  logic [IW-1:0]       idx,
    input  logic                sx,
    output logic [BW-1:0]       byte_out
);
    logic [BW-1:0] picked;

    // Index into the byte pool.
    always_comb picked = pool[idx*BW +: BW];

    // Apply sign replication when requested.
    always_comb byte_out = sx ? {BW{picked[BW-1]}} : picked;
endmodule

// File: rtl/perm_unit.sv
// Module: top of the byte permute unit. It combines index derivation, per-lane
// byte selection and one output register stage. Assumes inputs are known
// whenever in_valid is high. The reset is synchronous and active low.
module perm_unit
    import perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [SEL_W-1:0]  sel,
    input  logic [2:0]        mode,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    logic [IDX_W-1:0]         lane_idx [LANES];
    logic [LANES-1:0]         lane_sx;
    logic [SRC_N*BYTE_W-1:0]  byte_pool;
    logic [WORD_W-1:0]        perm_word;

    // Concatenate the operands so pool index k is source byte k.
    always_comb byte_pool = {opb, opa};

    perm_idx_gen #(.N_LANES(LANES), .IW(IDX_W)) u_idx (
        .mode (mode),
        .sel  (sel),
        .idx  (lane_idx),
        .sx   (lane_sx)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_mux
        perm_byte_sel #(.BW(BYTE_W), .N_SRC(SRC_N), .IW(IDX_W)) u_sel (
            .pool     (byte_pool),
            .idx      (lane_idx[i]),
            .sx       (lane_sx[i]),
            .byte_out (perm_word[i*BYTE_W +: BYTE_W])
        );
    end

    // Output stage: valid follows in_valid, and result loads on a valid operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= perm_word;
        end
    end
endmodule

// File: rtl/perm_unit_chk.sv
// Module: property checker for perm_unit, attached through bind below.
// Assumes inputs are known while in_valid is high.
module perm_unit_chk
    import perm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] opa,
    input logic [WORD_W-1:0] opb,
    input logic [SEL_W-1:0]  sel,
    input logic [2:0]        mode,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!out_valid && result == '0)); // R1
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(result)); // R2
    AST_REP8_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd3) |=> (result[7:0] == result[15:8] && result[15:8] == result[23:16]
                                        && result[23:16] == result[31:24])); // R7
    AST_REP16_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd6) |=> (result[15:0] == result[31:16])); // R8
    AST_CLAMPL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd4) |=> (result[31:24] == $past(opa[31:24]))); // R9
    AST_CLAMPR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd5) |=> (result[7:0] == $past(opa[7:0]))); // R10
endmodule

bind perm_unit perm_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .opb       (opb),
    .sel       (sel),
    .mode      (mode),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/sim_perm_unit.sv
// Bench: behavioural reference model, compared with the design on every clock.
module sim_perm_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [15:0] sel = '0;
    logic [2:0]  mode = '0;
    logic        out_valid;
    logic [31:0] result;

    int          n_run = 0;
    int          n_fail = 0;
    logic        exp_v = 1'b0;
    logic [31:0] exp_r = '0;
    string       exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    perm_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .sel(sel), .mode(mode), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] ref_perm(logic [31:0] a, logic [31:0] b,
                                             logic [15:0] s, logic [2:0] m);
        logic [63:0] pool = {b, a};
        logic [31:0] r = '0;
        int v = int'(s[1:0]);
        for (int i = 0; i < 4; i++) begin
            int k = 0;
            bit sg = 0;
            logic [7:0] by;
            case (m)
                3'd1: k = v + i;
                3'd2: k = (v - i + 8) % 8;
                3'd3: k = v;
                3'd4: k = (v > i) ? v : i;
                3'd5: k = (v < i) ? v : i;
                3'd6: k = 2 * (v % 2) + (i % 2);
                default: begin k = int'(s[4*i +: 3]); sg = s[4*i+3]; end
            endcase
            by = pool[k*8 +: 8];
            if (sg) by = {8{by[7]}};
            r[i*8 +: 8] = by;
        end
        return r;
    endfunction

    function automatic string tag_of(logic [2:0] m);
        case (m)
            3'd0: return "R3/R4";
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R9";
            3'd5: return "R10";
            3'd6: return "R8";
            default: return "R12";
        endcase
    endfunction

    // Check the previous cycle's expectation, then drive the next inputs.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] s, input logic [2:0] m, input string tag);
        @(negedge clk);
        n_run++;
        if (out_valid !== exp_v || result !== exp_r) begin
            n_fail++;
            $display("FAIL %s: valid=%0b result=%08h expected valid=%0b result=%08h",
                     exp_tag, out_valid, result, exp_v, exp_r);
        end
        in_valid = v; opa = a; opb = b; sel = s; mode = m;
        exp_v = v;
        if (v) exp_r = ref_perm(a, b, s, m);
        exp_tag = v ? tag : "R2";
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state is zero
        @(negedge clk);
        n_run++;
        if (out_valid !== 1'b0 || result !== 32'h0) begin
            n_fail++;
            $display("FAIL R1: valid=%0b result=%08h expected valid=0 result=00000000", out_valid, result);
        end
        rst_n = 1'b1;
        step(1, 32'h03020100, 32'h07060504, 16'h0123, 3'd0, "R3");
        step(1, 32'h03020100, 32'h07060504, 16'h7171, 3'd0, "R3");
        step(1, 32'hF322F100, 32'h77665544, 16'hBA98, 3'd0, "R4");
        step(1, 32'h33221100, 32'h77665544, 16'hBA98, 3'd0, "R4");
        step(1, 32'h03020100, 32'h07060504, 16'h0003, 3'd2, "R6");
        step(1, 32'h03020100, 32'h07060504, 16'h0002, 3'd1, "R5");
        step(1, 32'h03020100, 32'h07060504, 16'hFFF4, 3'd3, "R11");
        step(1, 32'h83828180, 32'h87868584, 16'hFFFD, 3'd6, "R11");
        step(1, 32'h03020100, 32'h07060504, 16'h0001, 3'd4, "R9");
        step(1, 32'h03020100, 32'h07060504, 16'h0002, 3'd5, "R10");
        step(1, 32'h03020100, 32'h07060504, 16'h0123, 3'd7, "R12");
        step(0, 32'hDEADBEEF, 32'hCAFEF00D, 16'h4567, 3'd0, "R2");
        step(0, 32'h11111111, 32'h22222222, 16'h0000, 3'd3, "R2");
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m = 3'($urandom_range(0, 7));
            step(($urandom_range(0, 3) != 0), $urandom, $urandom, 16'($urandom), m, tag_of(m));
        end
        // R1: reset in mid-run clears the output stage
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        exp_v = 1'b0; exp_r = '0; exp_tag = "R1";
        step(0, 32'h0, 32'h0, 16'h0, 3'd0, "R1");
        rst_n = 1'b1;
        step(0, 32'h0, 32'h0, 16'h0, 3'd0, "R2");
        step(0, 32'h0, 32'h0, 16'h0, 3'd0, "R2");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule